// File: doc/BRIEF.md
# Three-Wire Attenuator Command Transmitter

This block runs on the controller side of a serial volume attenuator. It accepts one attenuation request at a time through a valid/ready handshake. A request is either a level in dB or a mute. The block encodes the request into a one-byte code and puts a fixed all-zero channel address byte in front of it. It then shifts the 16-bit word out on three lines: a serial data line `sdo`, a serial clock `sck`, and an active-low frame strobe `frame_n`. The device commits the word when `frame_n` returns high.

All line timing is counted in system clock cycles and set by parameters:
- the setup interval from `frame_n` falling to the first clock rise;
- the length of the clock low phase;
- the length of the clock high phase;
- how early the data must settle before each rising edge;
- the idle gap after the word has been committed.

The clock is held low around both edges of `frame_n`. The data line changes only while the clock is low.

Top module: `atten_cmd_tx`

## Requirements
- R1: After reset, and whenever no request is in progress, `frame_n` is 1, `sck` is 0, `sdo` is 0 and `req_ready` is 1.
- R2: A frame carries 16 bits, most significant bit first. The first eight bits are the channel address 0x00 and the last eight are the code byte. Each bit is valid on `sdo` at the rising edge of `sck`.
- R3: The code byte equals the requested level when `req_mute` is 0 and the level is 62 or less. It is 0x3F when `req_mute` is 1 or the level is above 62.
- R4: `frame_n` falls in the first cycle after a request is accepted. The first `sck` rise comes exactly SETUP_CYC cycles after that fall.
- R5: `sck` is 0 in the cycle where `frame_n` falls, in the cycle where it rises, and in the cycle before it rises. `sck` is never 1 while `frame_n` is 1.
- R6: Each `sck` high phase lasts HI_CYC cycles. Each low phase between two high phases lasts LO_CYC cycles.
- R7: `sdo` never changes while `sck` stays high. Each bit appears DSU_CYC cycles before the rising edge that samples it.
- R8: `frame_n` rises LO_CYC cycles after the sixteenth `sck` fall. `sdo` returns to 0 in the same cycle.
- R9: `req_ready` falls in the cycle after acceptance. It stays low until GAP_CYC cycles after `frame_n` has risen. Requests presented while it is low are ignored.
- R10: Exactly 16 rising edges of `sck` occur in each interval where `frame_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_mute | input | 1 | Request mute instead of a level |
| req_level | input | LEVEL_W | Requested attenuation in dB |
| sdo | output | 1 | Serial data line |
| sck | output | 1 | Serial clock line |
| frame_n | output | 1 | Active-low frame strobe; the rising edge commits the word |

## Verification
The bench builds the block with SETUP_CYC=3, LO_CYC=2, HI_CYC=2, DSU_CYC=1 and GAP_CYC=3. Because the setup interval differs from the low phase, a mix-up between the first bit's timing and the later bits' timing shows up. Because DSU_CYC is smaller than LO_CYC, the data change point falls in the middle of a low phase, so an early or late update is caught. The short phases keep each frame near 70 cycles. This leaves room for these cases:
- boundary levels and clamped levels;
- mute requests;
- a request held during a busy frame;
- a request still asserted at the moment ready returns.

// File: rtl/atten_pkg.sv
package atten_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_LOW  = 3'd1,
      PH_HIGH = 3'd2,
      PH_TAIL = 3'd3,
      PH_GAP  = 3'd4
   } phase_t;
endpackage

// File: rtl/atten_code_enc.sv
module atten_code_enc #(
   parameter int LEVEL_W   = 7,
   parameter int CODE_W    = 8,
   parameter int MAX_LEVEL = 62,
   parameter int MUTE_CODE = 63
) (
   input  logic               mute,
   input  logic [LEVEL_W-1:0] level,
   output logic [CODE_W-1:0]  code
);
   localparam int LEVEL_TOP = (1 << LEVEL_W) - 1;

   logic over;

   generate
      if (LEVEL_TOP > MAX_LEVEL) begin : g_clamp
         assign over = (int'(level) > MAX_LEVEL);
      end else begin : g_noclamp
         assign over = 1'b0;
      end
   endgenerate

   assign code = (mute || over) ? CODE_W'(MUTE_CODE) : CODE_W'(level);
endmodule

// File: rtl/atten_phase_seq.sv
module atten_phase_seq
   import atten_pkg::*;
#(
   parameter int FRAME_W   = 16,
   parameter int SETUP_CYC = 4,
   parameter int LO_CYC    = 3,
   parameter int HI_CYC    = 3,
   parameter int DSU_CYC   = 2,
   parameter int GAP_CYC   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] word_in,
   output logic               idle,
   output logic               sdo,
   output logic               sck,
   output logic               frame_n
);
   localparam int MAX_A = (SETUP_CYC > LO_CYC) ? SETUP_CYC : LO_CYC;
   localparam int MAX_B = (HI_CYC > GAP_CYC) ? HI_CYC : GAP_CYC;
   localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W = $clog2(MAX_C + 1);
   localparam int IDX_W = $clog2(FRAME_W);

   phase_t             st_q, st_d;
   logic [CNT_W-1:0]   cnt_q, cnt_d;
   logic [IDX_W-1:0]   idx_q, idx_d;
   logic [FRAME_W-1:0] word_q, word_cur;
   logic               sdo_d, sck_d, frame_n_d;

   // The first bit uses the longer setup interval as its low phase.
   function automatic int low_len(input logic [IDX_W-1:0] i);
      return (int'(i) == FRAME_W - 1) ? SETUP_CYC : LO_CYC;
   endfunction

   // Take the new word straight from the input in the accept cycle,
   // so the first bit can be driven at the same edge.
   assign word_cur = start ? word_in : word_q;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q + 1'b1;
      idx_d = idx_q;
      unique case (st_q)
         PH_IDLE: begin
            cnt_d = '0;
            if (start) begin
               st_d  = PH_LOW;
               idx_d = IDX_W'(FRAME_W - 1);
            end
         end
         PH_LOW: begin
            if (int'(cnt_q) == low_len(idx_q) - 1) begin
               st_d  = PH_HIGH;
               cnt_d = '0;
            end
         end
         PH_HIGH: begin
            if (int'(cnt_q) == HI_CYC - 1) begin
               cnt_d = '0;
               if (idx_q == '0) begin
                  st_d = PH_TAIL;
               end else begin
                  st_d  = PH_LOW;
                  idx_d = idx_q - 1'b1;
               end
            end
         end
         PH_TAIL: begin
            if (int'(cnt_q) == LO_CYC - 1) begin
               st_d  = PH_GAP;
               cnt_d = '0;
            end
         end
         PH_GAP: begin
            if (int'(cnt_q) == GAP_CYC - 1) begin
               st_d  = PH_IDLE;
               cnt_d = '0;
            end
         end
         default: begin
            st_d  = PH_IDLE;
            cnt_d = '0;
         end
      endcase
   end

   // The line outputs are decoded from the next state and registered,
   // so the pins change only at clock edges and never glitch.
   always_comb begin
      frame_n_d = !(st_d == PH_LOW || st_d == PH_HIGH || st_d == PH_TAIL);
      sck_d     = (st_d == PH_HIGH);
      sdo_d     = sdo;
      if (st_d == PH_IDLE || st_d == PH_GAP) begin
         sdo_d = 1'b0;
      end else if (st_d == PH_LOW &&
                   int'(cnt_d) == low_len(idx_d) - DSU_CYC) begin
         sdo_d = word_cur[idx_d];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PH_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         word_q  <= '0;
         sdo     <= 1'b0;
         sck     <= 1'b0;
         frame_n <= 1'b1;
      end else begin
         st_q    <= st_d;
         cnt_q   <= cnt_d;
         idx_q   <= idx_d;
         word_q  <= word_cur;
         sdo     <= sdo_d;
         sck     <= sck_d;
         frame_n <= frame_n_d;
      end
   end

   assign idle = (st_q == PH_IDLE);
endmodule

// File: rtl/atten_cmd_tx.sv
module atten_cmd_tx #(
   parameter int LEVEL_W   = 7,
   parameter int ADDR_W    = 8,
   parameter int CODE_W    = 8,
   parameter int CHAN_ADDR = 0,
   parameter int MAX_LEVEL = 62,
   parameter int MUTE_CODE = 63,
   parameter int SETUP_CYC = 4,
   parameter int LO_CYC    = 3,
   parameter int HI_CYC    = 3,
   parameter int DSU_CYC   = 2,
   parameter int GAP_CYC   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_mute,
   input  logic [LEVEL_W-1:0] req_level,
   output logic               sdo,
   output logic               sck,
   output logic               frame_n
);
   localparam int FRAME_W = ADDR_W + CODE_W;

   // Parameter sanity checks at elaboration time.
   generate
      if (SETUP_CYC < 1 || LO_CYC < 1 || HI_CYC < 1 || GAP_CYC < 1) begin : g_bad_phase
         $error("atten_cmd_tx: every phase must last at least one cycle");
      end
      if (DSU_CYC < 1 || DSU_CYC > LO_CYC || DSU_CYC > SETUP_CYC) begin : g_bad_dsu
         $error("atten_cmd_tx: data setup must fit inside every low phase");
      end
      if (LEVEL_W > CODE_W || MUTE_CODE <= MAX_LEVEL) begin : g_bad_code
         $error("atten_cmd_tx: code byte cannot hold the level range");
      end
   endgenerate

   logic [CODE_W-1:0] code;
   logic              idle;
   logic              accept;

   assign req_ready = idle;
   assign accept    = req_valid && idle;

   atten_code_enc #(
      .LEVEL_W   (LEVEL_W),
      .CODE_W    (CODE_W),
      .MAX_LEVEL (MAX_LEVEL),
      .MUTE_CODE (MUTE_CODE)
   ) u_enc (
      .mute  (req_mute),
      .level (req_level),
      .code  (code)
   );

   atten_phase_seq #(
      .FRAME_W   (FRAME_W),
      .SETUP_CYC (SETUP_CYC),
      .LO_CYC    (LO_CYC),
      .HI_CYC    (HI_CYC),
      .DSU_CYC   (DSU_CYC),
      .GAP_CYC   (GAP_CYC)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .word_in ({ADDR_W'(CHAN_ADDR), code}),
      .idle    (idle),
      .sdo     (sdo),
      .sck     (sck),
      .frame_n (frame_n)
   );
endmodule

// File: rtl/atten_cmd_tx_chk.sv
module atten_cmd_tx_chk #(
   parameter int FRAME_W   = 16,
   parameter int SETUP_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic sdo,
   input logic sck,
   input logic frame_n
);
   logic [15:0] low_cnt;
   logic [7:0]  rise_cnt;
   logic        sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         rise_cnt <= '0;
         sck_d    <= 1'b0;
      end else begin
         sck_d    <= sck;
         low_cnt  <= frame_n ? 16'd0 : ((low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 16'd1);
         rise_cnt <= frame_n ? 8'd0 : rise_cnt + 8'((sck && !sck_d) ? 1 : 0);
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (frame_n && !sck)); // R1

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && !frame_n)); // R9

   AST_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_n) |-> !sck); // R5

   AST_RISE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_n) |-> (!sck && !$past(sck))); // R5

   AST_NO_CLK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> !frame_n); // R5

   AST_SETUP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sck) && rise_cnt == 8'd0) |-> (int'(low_cnt) >= SETUP_CYC)); // R4

   AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(sdo)); // R7

   AST_RISE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_n) |-> (int'(rise_cnt) == FRAME_W)); // R10
endmodule

bind atten_cmd_tx atten_cmd_tx_chk #(
   .FRAME_W   (ADDR_W + CODE_W),
   .SETUP_CYC (SETUP_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .sdo       (sdo),
   .sck       (sck),
   .frame_n   (frame_n)
);

// File: tb/atten_cmd_tx_bench.sv
module atten_cmd_tx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int S  = 3;
   localparam int LO = 2;
   localparam int HI = 2;
   localparam int DS = 1;
   localparam int GP = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_mute = 1'b0;
   logic [6:0] req_level = '0;
   logic       req_ready, sdo, sck, frame_n;

   atten_cmd_tx #(
      .SETUP_CYC (S), .LO_CYC (LO), .HI_CYC (HI), .DSU_CYC (DS), .GAP_CYC (GP)
   ) u_atten_cmd_tx (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
      .req_mute (req_mute), .req_level (req_level),
      .sdo (sdo), .sck (sck), .frame_n (frame_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int          total = 0;
   int          bad = 0;
   int          acc_cnt = 0;
   int          frames_done = 0;
   bit          exp_rdy = 1'b1;
   logic [3:0]  expq[$];            // {ready, frame_n, sck, sdo} per cycle
   logic [15:0] last_word = '0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Word a request should produce, straight from R2 and R3.
   function automatic logic [15:0] ref_word(input bit m, input logic [6:0] l);
      logic [7:0] c;
      c = (m || l > 7'd62) ? 8'h3F : {1'b0, l};
      return {8'h00, c};
   endfunction

   // Expected line waveform for one frame, one entry per cycle after acceptance.
   task automatic push_frame(input logic [15:0] w);
      for (int j = 0; j < S; j++) expq.push_back({3'b000, (j >= S - DS) ? w[15] : 1'b0});
      for (int i = 15; i >= 0; i--) begin
         for (int j = 0; j < HI; j++) expq.push_back({3'b001, w[i]});
         for (int j = 0; j < LO; j++) begin
            if (i > 0) expq.push_back({3'b000, (j >= LO - DS) ? w[i-1] : w[i]});
            else       expq.push_back({3'b000, w[0]});
         end
      end
      for (int j = 0; j < GP; j++) expq.push_back(4'b0100);
   endtask

   // Reference model: acceptance at the clock edge.
   always @(posedge clk) begin
      if (rst_n && req_valid && exp_rdy) begin
         last_word = ref_word(req_mute, req_level);
         push_frame(last_word);
         acc_cnt++;
      end
   end

   // Cycle-by-cycle compare and protocol observation.
   logic        sck_p = 1'b0, fn_p = 1'b1, sdo_p = 1'b0;
   logic [15:0] cap = '0;
   int          nrise = 0, lowc = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         logic [3:0] e;
         logic [3:0] a;
         e = 4'b1100;
         exp_rdy = 1'b1;
         if (expq.size() > 0) begin
            e = expq.pop_front();
            exp_rdy = 1'b0;
         end
         a = {req_ready, frame_n, sck, sdo};
         if (a[3] != e[3])      check(0, "R9 ready", a, e);
         else if (a[2] != e[2]) check(0, "R8 frame_n", a, e);
         else if (a[1] != e[1]) check(0, "R6 sck", a, e);
         else if (a[0] != e[0]) check(0, "R7 sdo", a, e);
         else                   check(1, "cycle", a, e);

         if (fn_p && !frame_n) begin
            check(!sck, "R5 sck at frame fall", sck, 0);
            cap = '0; nrise = 0; lowc = 0;
         end
         if (!frame_n && !sck && nrise == 0) lowc++;
         if (!frame_n && sck && !sck_p) begin
            cap = {cap[14:0], sdo};
            nrise++;
            if (nrise == 1) check(lowc == S, "R4 setup cycles", lowc, S);
         end
         if (sck && sck_p) check(sdo == sdo_p, "R7 data moved while high", sdo, sdo_p);
         if (!fn_p && frame_n) begin
            check(!sck_p && !sck, "R5 sck at frame rise", {sck_p, sck}, 0);
            check(nrise == 16, "R10 rise count", nrise, 16);
            check(cap[15:8] == 8'h00, "R2 address byte", cap[15:8], 0);
            check(cap[7:0] == last_word[7:0], "R3 code byte", cap[7:0], last_word[7:0]);
            frames_done++;
         end
         sck_p = sck; fn_p = frame_n; sdo_p = sdo;
      end
   end

   task automatic send(input bit m, input logic [6:0] l);
      int n;
      n = acc_cnt;
      @(negedge clk);
      req_valid <= 1'b1; req_mute <= m; req_level <= l;
      do @(negedge clk); while (acc_cnt == n);
      req_valid <= 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (expq.size() > 0 || !exp_rdy);
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(frame_n === 1'b1 && sck === 1'b0 && sdo === 1'b0 && req_ready === 1'b1,
            "R1 reset state", {req_ready, frame_n, sck, sdo}, 4'b1100);
      rst_n <= 1'b1;
      repeat (3) @(negedge clk);

      send(0, 7'd0);   wait_idle();
      send(0, 7'd1);   wait_idle();
      send(0, 7'd62);  wait_idle();    // largest level sent as is (R3)
      send(0, 7'd63);  wait_idle();    // clamped to the mute code (R3)
      send(0, 7'd100); wait_idle();
      send(0, 7'd127); wait_idle();
      send(1, 7'd5);   wait_idle();    // mute overrides level (R3)
      send(1, 7'd0);   wait_idle();
      send(0, 7'd42);  wait_idle();

      // R9: a request presented while busy is ignored.
      send(0, 7'd21);
      @(negedge clk);
      req_valid <= 1'b1; req_mute <= 1'b0; req_level <= 7'd7;
      repeat (5) @(negedge clk);
      req_valid <= 1'b0;
      wait_idle();
      check(acc_cnt == 10, "R9 busy request ignored", acc_cnt, 10);

      // Back to back: valid held while ready returns.
      send(0, 7'd33);
      send(0, 7'd17);
      wait_idle();
      check(frames_done == 12, "R10 frames completed", frames_done, 12);
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end
endmodule